// File: doc/BRIEF.md
# Greedy Nearest-Neighbour Test Vector Sequencer

This block stores a small set of test vectors and plays them out in an order that keeps input switching low. Slot 0 is always played first. Every later vector is the not-yet-played slot whose Hamming distance to the vector just played is smallest, and a tie goes to the lowest slot number. The result is an open path through all slots. No cost is counted for returning to the start.

Software or a test controller fills the slots through a simple write port while the engine is idle, then pulses `start`. Vectors leave on a valid/ready stream together with their slot index. Before each vector after the first, the engine spends one clock per slot comparing candidates, and `outValid` stays low during that search. One cycle after the last vector is accepted, a one-cycle done pulse presents the total number of input bit transitions over the whole emitted sequence.

Top module: `greedy_vec_order`

## Requirements
- R1: While `busy` is low, `ldEn` writes `ldData` into slot `ldIdx` at the clock edge. While `busy` is high, `ldEn` has no effect on the stored vectors.
- R2: A `start` seen at an edge while `busy` is low raises `busy` and `outValid` in the next cycle, and the first vector presented is slot 0. A `start` while `busy` is high is ignored.
- R3: One run presents every slot index exactly once, NUM_VEC vectors in total.
- R4: Each vector after the first is the unused slot with the smallest Hamming distance (count of differing bits) to the previously accepted vector.
- R5: When several unused slots share the smallest distance, the one with the lowest index is chosen.
- R6: After a vector is accepted and further vectors remain, `outValid` is low for exactly NUM_VEC cycles, one per candidate compared, and then rises with the final choice.
- R7: While `outValid` is high and `outReady` is low, `outValid`, `outIdx` and `outData` hold their values.
- R8: In the cycle after the last vector is accepted, `donePulse` is high for exactly one cycle and `totalCost` equals the sum of Hamming distances between consecutive emitted vectors. `busy` is low in the cycle after that.
- R9: After reset `busy`, `outValid` and `donePulse` are low, and all slots hold zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ldEn | input | 1 | Slot write strobe |
| ldIdx | input | $clog2(NUM_VEC) | Slot to write |
| ldData | input | VEC_W | Vector to store |
| start | input | 1 | Begin a sequencing run |
| busy | output | 1 | A run is in progress |
| outValid | output | 1 | Presented vector is final |
| outReady | input | 1 | Consumer accepts the presented vector |
| outIdx | output | $clog2(NUM_VEC) | Slot index of the presented vector |
| outData | output | VEC_W | Presented vector |
| donePulse | output | 1 | One-cycle end-of-run strobe |
| totalCost | output | $clog2(NUM_VEC*VEC_W+1) | Total input transitions over the run |

## Verification
The bound checker watches four things on every clock. It tracks which indices have already been emitted, so it catches a repeat or a first vector other than slot 0. It checks that outputs hold under backpressure, and it counts the idle gap between an accepted vector and the next valid one. It also keeps its own running sum of transitions between consecutive accepted vectors and compares that sum with `totalCost` at the done pulse. Whether each choice is really the nearest unused neighbour, how ties resolve, and whether writes or starts during a run are ignored can only be seen in the bench scenarios. The bench computes the greedy order from the loaded data and compares every output on every cycle, with patterns built to create distinct winners, full ties and stalls.

// File: rtl/greedy_vec_order_pkg.sv
package greedy_vec_order_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_EMIT = 2'd1,
    PH_SCAN = 2'd2,
    PH_FIN  = 2'd3
  } phase_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic loadWr;     // write a slot
    logic seqInit;    // clear run state, select slot 0
    logic emitAccept; // presented vector taken by consumer
    logic scanClear;  // restart candidate search
    logic scanStep;   // compare one candidate
  } ctrlStrobes_t;

endpackage

// File: rtl/gvo_datapath.sv
module gvo_datapath
  import greedy_vec_order_pkg::*;
#(
  parameter int NUM_VEC = 16,
  parameter int VEC_W   = 16,
  localparam int IW = $clog2(NUM_VEC),
  localparam int DW = $clog2(VEC_W + 1),
  localparam int CW = $clog2(NUM_VEC * VEC_W + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strb,
  input  logic [IW-1:0]    ldIdx,
  input  logic [VEC_W-1:0] ldData,
  output logic [VEC_W-1:0] outData,
  output logic [IW-1:0]    outIdx,
  output logic [CW-1:0]    totalCost,
  output logic             scanLast
);

  localparam logic [IW-1:0] LAST_IDX = IW'(NUM_VEC - 1);

  logic [VEC_W-1:0]   vecMem [NUM_VEC];
  logic [NUM_VEC-1:0] usedMask;
  logic [IW-1:0]      curIdx;
  logic [IW-1:0]      selIdx;
  logic [DW-1:0]      selDist;
  logic [IW-1:0]      candIdx;
  logic [IW-1:0]      bestIdx;
  logic [DW-1:0]      bestDist;
  logic               bestFound;
  logic [CW-1:0]      costAcc;

  logic [VEC_W-1:0]   diffBits;
  logic [DW-1:0]      candDist;
  logic               candTake;

  // vector storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_VEC; s++) vecMem[s] <= '0;
    end else if (strb.loadWr) begin
      for (int s = 0; s < NUM_VEC; s++) begin
        if (ldIdx == IW'(s)) vecMem[s] <= ldData;
      end
    end
  end

  // distance of the current candidate to the last emitted vector
  assign diffBits = vecMem[candIdx] ^ vecMem[curIdx];

  always_comb begin
    candDist = '0;
    for (int b = 0; b < VEC_W; b++) candDist = candDist + DW'(diffBits[b]);
  end

  // strict less-than keeps the lowest index on a tie
  assign candTake = !usedMask[candIdx] && (!bestFound || (candDist < bestDist));

  // run state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      usedMask <= '0;
      curIdx   <= '0;
      selIdx   <= '0;
      selDist  <= '0;
      costAcc  <= '0;
    end else begin
      if (strb.seqInit) begin
        usedMask <= '0;
        curIdx   <= '0;
        selIdx   <= '0;
        selDist  <= '0;
        costAcc  <= '0;
      end
      if (strb.emitAccept) begin
        usedMask[selIdx] <= 1'b1;
        costAcc          <= costAcc + CW'(selDist);
        curIdx           <= selIdx;
      end
      if (strb.scanStep && (candIdx == LAST_IDX)) begin
        selIdx  <= candTake ? candIdx  : bestIdx;
        selDist <= candTake ? candDist : bestDist;
      end
    end
  end

  // candidate search
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      candIdx   <= '0;
      bestIdx   <= '0;
      bestDist  <= '0;
      bestFound <= 1'b0;
    end else if (strb.scanClear) begin
      candIdx   <= '0;
      bestFound <= 1'b0;
    end else if (strb.scanStep) begin
      if (candTake) begin
        bestIdx   <= candIdx;
        bestDist  <= candDist;
        bestFound <= 1'b1;
      end
      candIdx <= candIdx + IW'(1);
    end
  end

  assign scanLast  = (candIdx == LAST_IDX);
  assign outData   = vecMem[selIdx];
  assign outIdx    = selIdx;
  assign totalCost = costAcc;

endmodule

// File: rtl/gvo_control.sv
module gvo_control
  import greedy_vec_order_pkg::*;
#(
  parameter int NUM_VEC = 16,
  localparam int IW = $clog2(NUM_VEC),
  localparam int EW = IW + 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         ldEn,
  input  logic         start,
  input  logic         outReady,
  input  logic         scanLast,
  output ctrlStrobes_t strb,
  output logic         busy,
  output logic         outValid,
  output logic         donePulse
);

  localparam logic [EW-1:0] LAST_EMIT = EW'(NUM_VEC - 1);

  phase_t        phase, phaseNext;
  logic [EW-1:0] emitCnt;

  always_comb begin
    strb      = '0;
    phaseNext = phase;
    case (phase)
      PH_IDLE: begin
        strb.loadWr = ldEn;
        if (start) begin
          strb.seqInit = 1'b1;
          phaseNext    = PH_EMIT;
        end
      end
      PH_EMIT: begin
        if (outReady) begin
          strb.emitAccept = 1'b1;
          if (emitCnt == LAST_EMIT) begin
            phaseNext = PH_FIN;
          end else begin
            strb.scanClear = 1'b1;
            phaseNext      = PH_SCAN;
          end
        end
      end
      PH_SCAN: begin
        strb.scanStep = 1'b1;
        if (scanLast) phaseNext = PH_EMIT;
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      emitCnt <= '0;
    end else begin
      phase <= phaseNext;
      if (strb.seqInit)         emitCnt <= '0;
      else if (strb.emitAccept) emitCnt <= emitCnt + EW'(1);
    end
  end

  assign busy      = (phase != PH_IDLE);
  assign outValid  = (phase == PH_EMIT);
  assign donePulse = (phase == PH_FIN);

endmodule

// File: rtl/greedy_vec_order.sv
module greedy_vec_order
  import greedy_vec_order_pkg::*;
#(
  parameter int NUM_VEC = 16,
  parameter int VEC_W   = 16,
  localparam int IW = $clog2(NUM_VEC),
  localparam int CW = $clog2(NUM_VEC * VEC_W + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ldEn,
  input  logic [IW-1:0]    ldIdx,
  input  logic [VEC_W-1:0] ldData,
  input  logic             start,
  output logic             busy,
  output logic             outValid,
  input  logic             outReady,
  output logic [IW-1:0]    outIdx,
  output logic [VEC_W-1:0] outData,
  output logic             donePulse,
  output logic [CW-1:0]    totalCost
);

  ctrlStrobes_t strb;
  logic         scanLast;

  gvo_control #(.NUM_VEC(NUM_VEC)) uCtrl (
    .clk(clk), .rstN(rstN), .ldEn(ldEn), .start(start), .outReady(outReady),
    .scanLast(scanLast), .strb(strb), .busy(busy), .outValid(outValid),
    .donePulse(donePulse)
  );

  gvo_datapath #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .ldIdx(ldIdx), .ldData(ldData),
    .outData(outData), .outIdx(outIdx), .totalCost(totalCost), .scanLast(scanLast)
  );

endmodule

// File: rtl/greedy_vec_order_chk.sv
module greedy_vec_order_chk #(
  parameter int NUM_VEC = 16,
  parameter int VEC_W   = 16,
  localparam int IW = $clog2(NUM_VEC),
  localparam int CW = $clog2(NUM_VEC * VEC_W + 1),
  localparam int GW = IW + 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             busy,
  input logic             outValid,
  input logic             outReady,
  input logic [IW-1:0]    outIdx,
  input logic [VEC_W-1:0] outData,
  input logic             donePulse,
  input logic [CW-1:0]    totalCost
);

  logic [NUM_VEC-1:0] seen;
  logic               firstPend;
  logic               afterAcc;
  logic [VEC_W-1:0]   lastData;
  logic [CW-1:0]      sumCost;
  logic [GW-1:0]      gapCnt;
  logic               accept;

  assign accept = outValid && outReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seen      <= '0;
      firstPend <= 1'b0;
      afterAcc  <= 1'b0;
      lastData  <= '0;
      sumCost   <= '0;
      gapCnt    <= '0;
    end else if (start && !busy) begin
      seen      <= '0;
      firstPend <= 1'b1;
      afterAcc  <= 1'b0;
      sumCost   <= '0;
      gapCnt    <= '0;
    end else if (accept) begin
      seen[outIdx] <= 1'b1;
      firstPend    <= 1'b0;
      afterAcc     <= 1'b1;
      lastData     <= outData;
      gapCnt       <= '0;
      if (!firstPend) sumCost <= sumCost + CW'($countones(outData ^ lastData));
    end else begin
      if (donePulse) afterAcc <= 1'b0;
      if (!outValid && (gapCnt < GW'(NUM_VEC))) gapCnt <= gapCnt + GW'(1);
    end
  end

  p_first_slot_r2: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && firstPend) |-> (outIdx == '0));

  p_no_repeat_r3: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !seen[outIdx]);

  p_search_gap_r6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && afterAcc) |-> (gapCnt == GW'(NUM_VEC)));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outIdx) && $stable(outData)));

  p_done_cost_r8: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> ((&seen) && (totalCost == sumCost)));

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> (!donePulse && !busy));

endmodule

bind greedy_vec_order greedy_vec_order_chk #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) uChk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .outValid(outValid),
  .outReady(outReady), .outIdx(outIdx), .outData(outData),
  .donePulse(donePulse), .totalCost(totalCost)
);

// File: tb/tb_greedy_vec_order.sv
`timescale 1ns/1ps
module tb_greedy_vec_order;

  localparam int N  = 16;
  localparam int W  = 16;
  localparam int IW = $clog2(N);
  localparam int CW = $clog2(N * W + 1);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          ldEn = 1'b0;
  logic [IW-1:0] ldIdx = '0;
  logic [W-1:0]  ldData = '0;
  logic          start = 1'b0;
  logic          outReady = 1'b0;
  logic          busy, outValid, donePulse;
  logic [IW-1:0] outIdx;
  logic [W-1:0]  outData;
  logic [CW-1:0] totalCost;

  always #5 clk = ~clk;

  greedy_vec_order #(.NUM_VEC(N), .VEC_W(W)) dut (
    .clk(clk), .rstN(rstN), .ldEn(ldEn), .ldIdx(ldIdx), .ldData(ldData),
    .start(start), .busy(busy), .outValid(outValid), .outReady(outReady),
    .outIdx(outIdx), .outData(outData), .donePulse(donePulse), .totalCost(totalCost)
  );

  int checks = 0;
  int fails  = 0;
  bit armed  = 0;
  bit finished = 0;

  // reference model state: 0 idle, 1 presenting, 2 searching, 3 done
  int        mPh = 0;
  int        pos = 0;
  int        gap = 0;
  int        expCost = 0;
  int        doneCost = -1;
  int        order[$];
  int        gotOrder[$];
  logic [W-1:0] mMem [N];
  logic [15:0]  lfsr = 16'hACE1;

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic void buildOrder();
    bit used [N];
    int cur = 0;
    for (int i = 0; i < N; i++) used[i] = 0;
    order.delete();
    order.push_back(0);
    used[0] = 1;
    expCost = 0;
    for (int k = 1; k < N; k++) begin
      int best = -1;
      int bd = 0;
      for (int j = 0; j < N; j++) begin
        if (!used[j]) begin
          int d = $countones(mMem[j] ^ mMem[cur]);
          if (best < 0 || d < bd) begin best = j; bd = d; end
        end
      end
      order.push_back(best);
      used[best] = 1;
      expCost += bd;
      cur = best;
    end
  endfunction

  // model advance at the active edge (reads pre-edge DUT values)
  always @(posedge clk) begin
    if (!rstN) begin
      mPh = 0;
      for (int i = 0; i < N; i++) mMem[i] = '0;
    end else begin
      if (outValid && outReady) gotOrder.push_back(int'(outIdx));
      if (donePulse) doneCost = int'(totalCost);
      case (mPh)
        0: begin
          if (ldEn) mMem[ldIdx] = ldData;
          if (start) begin buildOrder(); pos = 0; mPh = 1; gotOrder.delete(); end
        end
        1: if (outReady) begin
          if (pos == N - 1) mPh = 3;
          else begin pos++; gap = N; mPh = 2; end
        end
        2: begin gap--; if (gap == 0) mPh = 1; end
        default: mPh = 0;
      endcase
    end
  end

  // compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (rstN && armed) begin
      chk(int'(busy), int'(mPh != 0), "R2 busy");
      chk(int'(outValid), int'(mPh == 1), "R6 outValid");
      chk(int'(donePulse), int'(mPh == 3), "R8 donePulse");
      if (mPh == 1) begin
        chk(int'(outIdx), order[pos], "R4 outIdx");
        chk(int'(outData), int'(mMem[order[pos]]), "R7 outData");
      end
      if (mPh == 3) chk(int'(totalCost), expCost, "R8 totalCost");
    end
  end

  task automatic loadSlot(input int idx, input logic [W-1:0] d);
    @(negedge clk);
    ldEn = 1'b1; ldIdx = IW'(idx); ldData = d;
    @(negedge clk);
    ldEn = 1'b0;
  endtask

  // stallMode: random backpressure; noise: writes and starts during the run
  task automatic runSeq(input bit stallMode, input bit noise);
    @(negedge clk);
    start = 1'b1;
    outReady = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (mPh != 0) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      outReady = stallMode ? (lfsr[0] | lfsr[3]) : 1'b1;
      if (noise) begin
        start  = lfsr[5];
        ldEn   = lfsr[7];
        ldIdx  = lfsr[IW+1:2];
        ldData = ~lfsr;
      end
      @(negedge clk);
    end
    start = 1'b0; ldEn = 1'b0; outReady = 1'b0;
    @(negedge clk);
  endtask

  task automatic checkPermutation(input string tag);
    bit hit [N];
    int dup = 0;
    for (int i = 0; i < N; i++) hit[i] = 0;
    chk(gotOrder.size(), N, {tag, " emitted count"});
    foreach (gotOrder[i]) begin
      if (hit[gotOrder[i]]) dup++;
      hit[gotOrder[i]] = 1;
    end
    chk(dup, 0, {tag, " repeated index"});
    if (gotOrder.size() > 0) chk(gotOrder[0], 0, "R2 first index");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R3 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(int'(busy), 0, "R9 busy after reset");
    chk(int'(outValid), 0, "R9 outValid after reset");
    chk(int'(donePulse), 0, "R9 donePulse after reset");
    armed = 1;

    // all slots zero: every distance 0, lowest index wins each tie (R5, R9)
    runSeq(0, 0);
    checkPermutation("R3 zero slots");
    for (int i = 0; i < N; i++) chk(gotOrder[i], i, "R5 tie order zero slots");
    chk(doneCost, 0, "R8 cost zero slots");

    // scrambled patterns, free-flowing consumer (R1, R4)
    for (int i = 0; i < N; i++) loadSlot(i, W'((i * 40503 + 4660) ^ (i << 5)));
    runSeq(0, 0);
    checkPermutation("R3 scrambled");
    chk(doneCost, expCost, "R8 cost scrambled");

    // same data with stalls (R7)
    runSeq(1, 0);
    checkPermutation("R3 stalled");

    // one-hot slots: all pairwise distances 2, tie rule picks ascending (R5)
    for (int i = 0; i < N; i++) loadSlot(i, W'(1) << i);
    runSeq(1, 0);
    for (int i = 0; i < N; i++) chk(gotOrder[i], i, "R5 tie order one-hot");
    chk(doneCost, 2 * (N - 1), "R8 cost one-hot");

    // directed nearest pick: slot 5 one bit from slot 0, rest far (R4)
    loadSlot(0, 16'h0000);
    for (int i = 1; i < N; i++) loadSlot(i, 16'hFFFF);
    loadSlot(5, 16'h0001);
    runSeq(0, 0);
    chk(gotOrder[1], 5, "R4 nearest second pick");
    chk(gotOrder[2], 1, "R5 lowest index among far slots");
    chk(doneCost, 16, "R8 cost directed");

    // writes and starts during a run are ignored (R1, R2)
    for (int i = 0; i < N; i++) loadSlot(i, W'(i * 4369 + 7) ^ W'(i << 9));
    runSeq(1, 1);
    checkPermutation("R3 noisy run");
    runSeq(0, 0);
    checkPermutation("R1 data kept after noisy run");
    chk(doneCost, expCost, "R1 cost unchanged after ignored writes");

    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

endmodule